// File: doc/BRIEF.md
# Calibration Offset and Gain Corrector

This block turns raw converter codes into calibrated codes and derives the two coefficients that make the correction. An offset register holds the code measured at the zero point. A gain register holds an unsigned fixed-point factor in which 2^22 means 1.0. Every accepted sample has the offset taken off first. The signed difference is then multiplied by the gain, scaled back, moved onto the output range and clamped. Codes are 24-bit offset-binary. In unipolar range the zero point is code 0. In bipolar range it is midscale, 0x800000.

A calibration controller drives two pulses. The zero-point pulse stores its code as the offset and leaves the gain alone. The full-point pulse starts an iterative divider. The divider computes the gain as the ideal span divided by the measured span, which is the full-point code minus the offset. While it runs a busy pin is high. Software can also write either coefficient directly. Samples enter and leave on valid/ready streams. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. An output sits in a register until the edge where `out_valid` and `out_ready` are both high. While the output is stalled, the input is stalled too.

Top module: `cal_datapath`

## Requirements
- R1: After reset `out_valid` is low, the offset is 0 and the gain is 0x400000, so a unipolar sample comes out unchanged.
- R2: An accepted sample appears on `out_code` with `out_valid` high after the accepting edge. Its value is base + floor((code - offset) * gain / 2^22). The base is 0 when `bipolar` is 0 and 0x800000 when `bipolar` is 1.
- R3: That result is clamped to the range 0 to 0xFFFFFF.
- R4: A `cal_zero_ld` pulse stores `cal_code` as the offset and leaves the gain unchanged.
- R5: A `cal_full_go` pulse sets the gain to min(floor(ideal * 2^22 / span), 0xFFFFFF). Here span = `cal_code` - offset. The ideal value is 0xFFFFFF in unipolar range and 0x7FFFFF in bipolar range. A span of zero or less gives 0xFFFFFF.
- R6: `cal_busy` rises after a `cal_full_go` pulse and stays high for exactly 47 cycles. `in_ready` is low while it is high. A `cal_full_go` pulse during busy is ignored.
- R7: `usr_off_we` or `usr_gain_we` loads `usr_wdata` into that coefficient. A gain write while `cal_busy` is high is ignored.
- R8: While `out_valid` is high and `out_ready` is low, `out_code` holds and `in_ready` is low.
- R9: A sample accepted on the same edge as a coefficient write uses the old coefficient. The new value applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bipolar | input | 1 | 1 selects the bipolar range |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Raw sample may be accepted |
| in_code | input | 24 | Raw conversion code |
| out_valid | output | 1 | Corrected sample valid |
| out_ready | input | 1 | Downstream accepts the corrected sample |
| out_code | output | 24 | Corrected code |
| cal_zero_ld | input | 1 | Load the offset from the zero-point code |
| cal_full_go | input | 1 | Start the gain computation from the full-point code |
| cal_code | input | 24 | Code measured at the calibration point |
| cal_busy | output | 1 | Gain computation in progress |
| usr_off_we | input | 1 | Direct offset write |
| usr_gain_we | input | 1 | Direct gain write |
| usr_wdata | input | 24 | Direct write data |

## Verification
A corrupt offset or gain register is never seen directly. It shows up in the first corrected sample that follows, as a wrong code on `out_code` one cycle after acceptance. The wrong code is off by a constant for an offset fault and off by a factor for a gain fault. A divider fault shows only after `cal_busy` falls, and only through the next sample. If the divider ends too early or too late, the length of the busy window changes. If a stalled output is handled wrongly, a code changes or is lost while `out_ready` is low.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic {RNG_UNI = 1'b0, RNG_BIP = 1'b1} rng_e;
endpackage

// File: rtl/cal_apply.sv
module cal_apply #(
  parameter int DW   = 24,
  parameter int FRAC = 22
) (
  input  cal_pkg::rng_e   rng,
  input  logic [DW-1:0]   code,
  input  logic [DW-1:0]   off,
  input  logic [DW-1:0]   gain,
  output logic [DW-1:0]   res
);
  localparam int SW = 2*DW + 2;
  localparam logic [SW-1:0] MIDV = {{(SW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
  localparam logic [SW-1:0] MAXV = {{(SW-DW){1'b0}}, {DW{1'b1}}};

  logic signed [DW:0]   diff;
  logic signed [SW-1:0] prod, scaled, sum, base;

  always_comb begin
    // offset removed before the gain multiply
    diff   = $signed({1'b0, code}) - $signed({1'b0, off});
    prod   = $signed({{(DW+1){diff[DW]}}, diff}) * $signed({{(DW+2){1'b0}}, gain});
    scaled = prod >>> FRAC;
    base   = (rng == cal_pkg::RNG_BIP) ? $signed(MIDV) : '0;
    sum    = scaled + base;
    if (sum < 0)                  res = '0;
    else if (sum > $signed(MAXV)) res = '1;
    else                          res = sum[DW-1:0];
  end
endmodule

// File: rtl/cal_gain_div.sv
module cal_gain_div #(
  parameter int DW   = 24,
  parameter int NUMW = 46
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NUMW-1:0] num,
  input  logic [DW-1:0]   den,
  output logic            busy,
  output logic            done,
  output logic [NUMW-1:0] quo
);
  localparam int CW = $clog2(NUMW);

  logic [DW-1:0] rem, den_r;
  logic [CW-1:0] cnt;
  logic [DW:0]   pre, dif;
  logic          take;

  always_comb begin
    pre  = {rem, quo[NUMW-1]};
    dif  = pre - {1'b0, den_r};
    take = (pre >= {1'b0, den_r});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      den_r <= '0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt   <= '0;
        rem   <= '0;
        den_r <= den;
        quo   <= num;
      end else if (busy) begin
        rem <= take ? dif[DW-1:0] : pre[DW-1:0];
        quo <= {quo[NUMW-2:0], take};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(NUMW-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath #(
  parameter int DW   = 24,
  parameter int FRAC = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bipolar,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_code,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_code,
  input  logic          cal_zero_ld,
  input  logic          cal_full_go,
  input  logic [DW-1:0] cal_code,
  output logic          cal_busy,
  input  logic          usr_off_we,
  input  logic          usr_gain_we,
  input  logic [DW-1:0] usr_wdata
);
  localparam int NUMW = DW + FRAC;
  localparam logic [DW-1:0] UNITY = DW'(1) << FRAC;

  cal_pkg::rng_e   rng;
  logic [DW-1:0]   off_r, gain_r, corr, ideal, den;
  logic [NUMW-1:0] num, quo;
  logic signed [DW:0] span;
  logic            div_busy, div_done, accept;

  assign rng      = bipolar ? cal_pkg::RNG_BIP : cal_pkg::RNG_UNI;
  assign cal_busy = div_busy | div_done;
  assign in_ready = !cal_busy && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  always_comb begin
    ideal = bipolar ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
    num   = {ideal, {FRAC{1'b0}}};
    span  = $signed({1'b0, cal_code}) - $signed({1'b0, off_r});
    den   = span[DW] ? '0 : span[DW-1:0];
  end

  cal_gain_div #(.DW(DW), .NUMW(NUMW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(cal_full_go && !cal_busy),
    .num(num), .den(den), .busy(div_busy), .done(div_done), .quo(quo)
  );

  cal_apply #(.DW(DW), .FRAC(FRAC)) u_apply (
    .rng(rng), .code(in_code), .off(off_r), .gain(gain_r), .res(corr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_r  <= '0;
      gain_r <= UNITY;
    end else begin
      if (usr_off_we)       off_r <= usr_wdata;
      else if (cal_zero_ld) off_r <= cal_code;
      if (div_done)
        gain_r <= (|quo[NUMW-1:DW]) ? '1 : quo[DW-1:0];
      else if (usr_gain_we && !cal_busy)
        gain_r <= usr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_code  <= corr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_datapath_chk.sv
module cal_datapath_chk #(
  parameter int DW   = 24,
  parameter int FRAC = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_code,
  input logic          cal_full_go,
  input logic          cal_busy
);
  localparam int BUSY_CYC = DW + FRAC + 1;
  logic [15:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        bcnt <= '0;
    else if (cal_busy) bcnt <= bcnt + 1'b1;
    else               bcnt <= '0;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !in_ready);
  p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy) |-> $past(cal_full_go));
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> bcnt == 16'(BUSY_CYC));
  p_out_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind cal_datapath cal_datapath_chk #(.DW(DW), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .cal_full_go(cal_full_go), .cal_busy(cal_busy)
);

// File: tb/sim_cal_datapath.sv
module sim_cal_datapath;
  logic clk = 0, rst_n = 0, bipolar = 0;
  logic in_valid = 0, out_ready = 1, cal_zero_ld = 0, cal_full_go = 0;
  logic usr_off_we = 0, usr_gain_we = 0;
  logic [23:0] in_code = 0, cal_code = 0, usr_wdata = 0;
  logic in_ready, out_valid, cal_busy;
  logic [23:0] out_code;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  cal_datapath u0 (
    .clk(clk), .rst_n(rst_n), .bipolar(bipolar), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_code(out_code), .cal_zero_ld(cal_zero_ld),
    .cal_full_go(cal_full_go), .cal_code(cal_code), .cal_busy(cal_busy),
    .usr_off_we(usr_off_we), .usr_gain_we(usr_gain_we), .usr_wdata(usr_wdata)
  );

  typedef struct packed {
    logic        bip;
    logic [23:0] off, gain, code, exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 24'h000000, 24'h400000, 24'h123456, 24'h123456},
    '{1'b0, 24'h000100, 24'h400000, 24'h000050, 24'h000000},
    '{1'b0, 24'h000010, 24'h800000, 24'h000110, 24'h000200},
    '{1'b0, 24'h000000, 24'h800000, 24'h900000, 24'hFFFFFF},
    '{1'b1, 24'h800000, 24'h400000, 24'h812345, 24'h812345},
    '{1'b1, 24'h800010, 24'h200000, 24'h800000, 24'h7FFFF8},
    '{1'b1, 24'h800000, 24'h200000, 24'h800003, 24'h800001},
    '{1'b1, 24'h800000, 24'h200000, 24'h7FFFFD, 24'h7FFFFE},
    '{1'b1, 24'h000000, 24'h800000, 24'h100000, 24'hA00000},
    '{1'b1, 24'hF00000, 24'hC00000, 24'h000000, 24'h000000},
    '{1'b0, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'h000000},
    '{1'b0, 24'h000000, 24'h400001, 24'hFFFFFF, 24'hFFFFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic send(input logic [23:0] code, input logic [23:0] exp, input string tag);
    @(negedge clk);
    in_code = code; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    check(tag, 32'({out_valid, out_code}), 32'({1'b1, exp}));
  endtask

  task automatic uwrite(input bit is_gain, input logic [23:0] d);
    @(negedge clk);
    usr_wdata = d; usr_off_we = !is_gain; usr_gain_we = is_gain;
    @(negedge clk);
    usr_off_we = 0; usr_gain_we = 0;
  endtask

  task automatic zero_ld(input logic [23:0] c);
    @(negedge clk);
    cal_code = c; cal_zero_ld = 1;
    @(negedge clk);
    cal_zero_ld = 0;
  endtask

  task automatic full_go(input logic [23:0] c, output int n);
    @(negedge clk);
    cal_code = c; cal_full_go = 1;
    @(negedge clk);
    cal_full_go = 0;
    n = 0;
    while (cal_busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    send(24'h5A5A5A, 24'h5A5A5A, "R1 unity identity");

    foreach (VECS[i]) begin
      bipolar = VECS[i].bip;
      uwrite(0, VECS[i].off);
      uwrite(1, VECS[i].gain);
      send(VECS[i].code, VECS[i].exp, $sformatf("R2 R3 R7 vector %0d", i));
    end

    // R9: write on the same edge as acceptance
    bipolar = 0;
    uwrite(0, 24'h0); uwrite(1, 24'h400000);
    @(negedge clk);
    in_code = 24'h000100; in_valid = 1; usr_wdata = 24'h800000; usr_gain_we = 1;
    @(negedge clk);
    in_valid = 0; usr_gain_we = 0;
    check("R9 old gain on same edge", 32'({out_valid, out_code}), 32'({1'b1, 24'h000100}));
    send(24'h000100, 24'h000200, "R9 new gain next sample");

    // R8: back-pressure
    uwrite(1, 24'h400000);
    @(negedge clk);
    out_ready = 0;
    in_code = 24'h0000AA; in_valid = 1;
    @(negedge clk);
    in_code = 24'h0000BB;
    for (int k = 0; k < 3; k++) begin
      check("R8 in_ready low when stalled", 32'(in_ready), 32'd0);
      check("R8 output held", 32'({out_valid, out_code}), 32'({1'b1, 24'h0000AA}));
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R8 next sample after release", 32'({out_valid, out_code}), 32'({1'b1, 24'h0000BB}));

    // R4 R5 R6 unipolar calibration
    bipolar = 0;
    zero_ld(24'h000100);
    full_go(24'hF00100, n);
    check("R6 busy length", 32'(n), 32'd47);
    send(24'hF00100, 24'hFFFFFF, "R5 unipolar full point");
    send(24'h000100, 24'h000000, "R5 unipolar zero point");
    send(24'h780100, 24'h7FFFFF, "R5 unipolar half span");
    zero_ld(24'h000200);
    send(24'h780200, 24'h7FFFFF, "R4 offset only, gain kept");

    // R5 bipolar calibration
    bipolar = 1;
    zero_ld(24'h800000);
    full_go(24'hC00000, n);
    send(24'hC00000, 24'hFFFFFF, "R5 bipolar full point");
    send(24'hA00000, 24'hBFFFFF, "R5 bipolar half span");
    send(24'h800000, 24'h800000, "R5 bipolar midscale");
    full_go(24'h800001, n);
    send(24'h800001, 24'h800003, "R5 tiny span saturates gain");
    uwrite(1, 24'h400000);
    full_go(24'h7FFFFF, n);
    send(24'h800001, 24'h800003, "R5 negative span saturates gain");

    // R6 R7: interference while busy
    bipolar = 0;
    zero_ld(24'h000000);
    @(negedge clk);
    cal_code = 24'h800000; cal_full_go = 1;
    @(negedge clk);
    cal_full_go = 0;
    n = 1;
    repeat (5) begin @(negedge clk); n++; end
    check("R6 in_ready low while busy", 32'(in_ready), 32'd0);
    usr_wdata = 24'h400000; usr_gain_we = 1;
    cal_code = 24'h400000; cal_full_go = 1;
    @(negedge clk); n++;
    usr_gain_we = 0; cal_full_go = 0;
    while (cal_busy) begin n++; @(negedge clk); end
    check("R6 restart ignored, busy length", 32'(n - 1), 32'd47);
    send(24'h400000, 24'h7FFFFF, "R7 gain write during busy ignored");

    summary();
  end
endmodule